// File: doc/BRIEF.md
# CCD Horizontal Readout Sequencer

This block drives the horizontal output register of a frame-transfer CCD one line at a time. A master clock runs at six times the pixel rate. Each pixel period is therefore split into six slots, and the three register phases, the reset-gate pulse and the summing-gate pulse are all placed on that grid. A pixel rate of 40 MHz needs a 240 MHz master clock. A single trigger starts one line. The block then walks the line's fixed sequence of pixel classes, with a class code for the digitizer and a clamp window over the trailing dark run. It then enters a quiet horizontal gap, and flags the first cycle of that gap so the vertical sequencer can shift the next row in.

The line is 1184 pixel periods long. The first 1079 carry charge transport and form the class sequence:

- dummy cells
- dark reference
- timing
- active
- timing
- dark reference

The last 105 are the gap. All run lengths are parameters. Outputs are registered logic levels. Level shifting and the multi-level clock drivers sit outside this block.

Top module: `ccd_hline_seq`

## Requirements
- R1: After reset, and at any time no line is in progress, every output is low and `pix_class` is 2'b00.
- R2: A `line_start` pulse sampled high at a clock edge, while `enable` is high and the block is idle, makes the outputs show pixel 0, slot 0 two edges later. Line cycle index t counts from that point, with pixel p = t/6 and slot s = t%6.
- R3: `pix_class` encodes 2'b00 dummy/blank, 2'b01 dark reference, 2'b10 timing, 2'b11 active. Over pixels 0..1078 it takes the runs 7×00, 20×01, 4×10, 1024×11, 4×10 and 20×01. It is 00 in the gap.
- R4: During clocked pixels, `reg_c1` is high in slots 0–2, `reg_c2` in slots 2–4 and `reg_c3` in slots 4, 5 and 0. Each phase is high for half a pixel period and is shifted two slots (120°) from the previous phase.
- R5: `reset_gate` is high only in slot 0 of each clocked pixel.
- R6: `sum_gate` equals `reg_c3` during clocked pixels and is low otherwise.
- R7: `clamp_win` is high exactly during pixels 1059..1078, the trailing dark run.
- R8: During the 105-pixel gap (pixels 1079..1183), `reg_c1`, `reg_c2`, `reg_c3`, `reset_gate`, `sum_gate` and `clamp_win` are low.
- R9: `gap_start` is high for exactly one cycle, at pixel 1079 slot 0.
- R10: A line lasts 1184×6 cycles and the block then returns to idle. `line_start` pulses during a line have no effect on that line.
- R11: Dropping `enable` during a line ends the line. The outputs show one more slot and then go idle. `line_start` is ignored while `enable` is low.
- R12: `pix_class` changes only on pixel boundaries (slot 0) while a line is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, six times the pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Allows lines to start; low aborts a line |
| line_start | input | 1 | Starts one line when idle |
| reg_c1 | output | 1 | Register phase 1 |
| reg_c2 | output | 1 | Register phase 2 |
| reg_c3 | output | 1 | Register phase 3 |
| reset_gate | output | 1 | Output-node reset pulse |
| sum_gate | output | 1 | Summing-gate pulse |
| clamp_win | output | 1 | Black-level clamp window |
| pix_class | output | 2 | Class of the pixel being output |
| gap_start | output | 1 | One-cycle strobe at the start of the gap |

## Verification
The bench targets the following corner cases:

- **Run boundaries.** A design that miscounts a run length shifts every later class edge and the clamp window by whole pixels.
- **Start latency.** An off-by-one in the trigger latency offsets the whole line by one slot.
- **Phase wrap.** A phase formula that fails to wrap would leave `reg_c3` low in slot 0.
- **Triggers during a line and at the last slot.** A design that re-arms on such a trigger would restart or extend the line.
- **Aborts at random slots.** A design that finishes the line or clears the outputs too early would show the wrong final slot or a stale clock after the abort.

// File: rtl/ccd_hseq_pkg.sv
package ccd_hseq_pkg;

    // Sub-pixel slots per pixel period (three phases, two slots apart)
    localparam int SLOTS      = 6;
    localparam int PHASES     = 3;
    localparam int PH_SHIFT   = SLOTS / PHASES;
    localparam int PH_HIGH    = SLOTS / 2;

    // Default run lengths of one line
    localparam int DEF_DUMMY  = 7;
    localparam int DEF_DARK   = 20;
    localparam int DEF_TIMING = 4;
    localparam int DEF_ACTIVE = 1024;
    localparam int DEF_GAP    = 105;

    typedef enum logic [1:0] {
        PC_BLANK  = 2'd0,
        PC_DARK   = 2'd1,
        PC_TIMING = 2'd2,
        PC_ACTIVE = 2'd3
    } pix_class_e;

    typedef logic [2:0] slot_t;

    typedef struct packed {
        logic c1;
        logic c2;
        logic c3;
        logic rg;
        logic sg;
    } hclk_t;

    typedef struct packed {
        hclk_t      clks;
        logic       clamp;
        pix_class_e pclass;
        logic       gap_start;
    } hseq_out_t;

    // Phase ph is high for PH_HIGH slots starting at slot ph*PH_SHIFT
    function automatic logic phase_high(slot_t s, int ph);
        int d;
        d = (int'(s) - ph * PH_SHIFT + SLOTS) % SLOTS;
        return d < PH_HIGH;
    endfunction

endpackage

// File: rtl/ccd_hseq_timebase.sv
module ccd_hseq_timebase
    import ccd_hseq_pkg::*;
#(
    parameter int LINE_PIX = 1184,
    localparam int PIX_W   = $clog2(LINE_PIX)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             trigger,
    output logic             busy,
    output slot_t            slot,
    output logic [PIX_W-1:0] pix
);
    localparam slot_t            LAST_SLOT = slot_t'(SLOTS - 1);
    localparam logic [PIX_W-1:0] LAST_PIX  = PIX_W'(LINE_PIX - 1);

    logic slot_wrap;
    logic line_end;

    assign slot_wrap = (slot == LAST_SLOT);
    assign line_end  = slot_wrap && (pix == LAST_PIX);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            slot <= '0;
            pix  <= '0;
        end else if (!enable) begin
            busy <= 1'b0;
            slot <= '0;
            pix  <= '0;
        end else if (!busy) begin
            slot <= '0;
            pix  <= '0;
            busy <= trigger;
        end else begin
            if (slot_wrap) begin
                slot <= '0;
                pix  <= pix + 1'b1;
            end else begin
                slot <= slot + 1'b1;
            end
            if (line_end) begin
                busy <= 1'b0;
                pix  <= '0;
            end
        end
    end
endmodule

// File: rtl/ccd_hseq_classifier.sv
module ccd_hseq_classifier
    import ccd_hseq_pkg::*;
#(
    parameter int N_DUMMY  = DEF_DUMMY,
    parameter int N_DARK   = DEF_DARK,
    parameter int N_TIMING = DEF_TIMING,
    parameter int N_ACTIVE = DEF_ACTIVE,
    parameter int PIX_W    = 11
) (
    input  logic             busy,
    input  slot_t            slot,
    input  logic [PIX_W-1:0] pix,
    output pix_class_e       pclass,
    output logic             clocked,
    output logic             clamp,
    output logic             gap_start
);
    // Run end boundaries (exclusive), in readout order
    localparam int E_DUMMY = N_DUMMY;
    localparam int E_DARK0 = E_DUMMY + N_DARK;
    localparam int E_TIM0  = E_DARK0 + N_TIMING;
    localparam int E_ACT   = E_TIM0 + N_ACTIVE;
    localparam int E_TIM1  = E_ACT + N_TIMING;
    localparam int E_DARK1 = E_TIM1 + N_DARK;

    localparam logic [PIX_W-1:0] B0 = PIX_W'(E_DUMMY);
    localparam logic [PIX_W-1:0] B1 = PIX_W'(E_DARK0);
    localparam logic [PIX_W-1:0] B2 = PIX_W'(E_TIM0);
    localparam logic [PIX_W-1:0] B3 = PIX_W'(E_ACT);
    localparam logic [PIX_W-1:0] B4 = PIX_W'(E_TIM1);
    localparam logic [PIX_W-1:0] B5 = PIX_W'(E_DARK1);

    always_comb begin
        pclass    = PC_BLANK;
        clocked   = 1'b0;
        clamp     = 1'b0;
        gap_start = 1'b0;
        if (busy) begin
            clocked = (pix < B5);
            if (pix < B0) begin
                pclass = PC_BLANK;
            end else if (pix < B1) begin
                pclass = PC_DARK;
            end else if (pix < B2) begin
                pclass = PC_TIMING;
            end else if (pix < B3) begin
                pclass = PC_ACTIVE;
            end else if (pix < B4) begin
                pclass = PC_TIMING;
            end else if (pix < B5) begin
                pclass = PC_DARK;
                clamp  = 1'b1;
            end
            gap_start = (pix == B5) && (slot == '0);
        end
    end
endmodule

// File: rtl/ccd_hseq_phasegen.sv
module ccd_hseq_phasegen
    import ccd_hseq_pkg::*;
(
    input  logic  clocked,
    input  slot_t slot,
    output hclk_t clks
);
    logic [PHASES-1:0] ph_on;

    for (genvar ph = 0; ph < PHASES; ph++) begin : g_phase
        assign ph_on[ph] = clocked && phase_high(slot, ph);
    end

    assign clks.c1 = ph_on[0];
    assign clks.c2 = ph_on[1];
    assign clks.c3 = ph_on[2];
    assign clks.rg = clocked && (slot == '0);
    assign clks.sg = ph_on[PHASES-1];
endmodule

// File: rtl/ccd_hline_seq.sv
module ccd_hline_seq
    import ccd_hseq_pkg::*;
#(
    parameter int N_DUMMY  = DEF_DUMMY,
    parameter int N_DARK   = DEF_DARK,
    parameter int N_TIMING = DEF_TIMING,
    parameter int N_ACTIVE = DEF_ACTIVE,
    parameter int N_GAP    = DEF_GAP
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       line_start,
    output logic       reg_c1,
    output logic       reg_c2,
    output logic       reg_c3,
    output logic       reset_gate,
    output logic       sum_gate,
    output logic       clamp_win,
    output logic [1:0] pix_class,
    output logic       gap_start
);
    localparam int CLOCKED_PIX = N_DUMMY + 2 * (N_DARK + N_TIMING) + N_ACTIVE;
    localparam int LINE_PIX    = CLOCKED_PIX + N_GAP;
    localparam int PIX_W       = $clog2(LINE_PIX);

    logic             busy;
    slot_t            slot;
    logic [PIX_W-1:0] pix;
    logic             clocked;
    hseq_out_t        nxt;
    hseq_out_t        out_q;

    ccd_hseq_timebase #(.LINE_PIX(LINE_PIX)) u_tb (
        .clk     (clk),
        .rst     (rst),
        .enable  (enable),
        .trigger (line_start),
        .busy    (busy),
        .slot    (slot),
        .pix     (pix)
    );

    ccd_hseq_classifier #(
        .N_DUMMY  (N_DUMMY),
        .N_DARK   (N_DARK),
        .N_TIMING (N_TIMING),
        .N_ACTIVE (N_ACTIVE),
        .PIX_W    (PIX_W)
    ) u_cls (
        .busy      (busy),
        .slot      (slot),
        .pix       (pix),
        .pclass    (nxt.pclass),
        .clocked   (clocked),
        .clamp     (nxt.clamp),
        .gap_start (nxt.gap_start)
    );

    ccd_hseq_phasegen u_ph (
        .clocked (clocked),
        .slot    (slot),
        .clks    (nxt.clks)
    );

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= nxt;
    end

    assign reg_c1     = out_q.clks.c1;
    assign reg_c2     = out_q.clks.c2;
    assign reg_c3     = out_q.clks.c3;
    assign reset_gate = out_q.clks.rg;
    assign sum_gate   = out_q.clks.sg;
    assign clamp_win  = out_q.clamp;
    assign pix_class  = out_q.pclass;
    assign gap_start  = out_q.gap_start;
endmodule

// File: rtl/ccd_hline_seq_checker.sv
module ccd_hline_seq_checker (
    input logic       clk,
    input logic       rst,
    input logic       busy_st,
    input logic       c1,
    input logic       c2,
    input logic       c3,
    input logic       rg,
    input logic       sg,
    input logic       clamp,
    input logic [1:0] pclass,
    input logic       done
);
    // R4: the three phases never overlap all at once
    a_r4_no_triple_high: assert property (@(posedge clk) disable iff (rst)
        $countones({c1, c2, c3}) <= 2);

    // R5: reset-gate pulse lasts a single slot
    a_r5_rg_one_slot: assert property (@(posedge clk) disable iff (rst)
        rg |=> !rg);

    // R5, R4: reset-gate pulse falls in the C1/C3 overlap slot
    a_r5_rg_in_overlap: assert property (@(posedge clk) disable iff (rst)
        rg |-> (c1 && c3 && !c2));

    // R6: summing gate never high without C3
    a_r6_sg_with_c3: assert property (@(posedge clk) disable iff (rst)
        sg |-> c3);

    // R7: clamp window lies inside a dark-reference run
    a_r7_clamp_dark: assert property (@(posedge clk) disable iff (rst)
        clamp |-> (pclass == 2'd1));

    // R8, R9: gap start is quiet
    a_r8_gap_quiet: assert property (@(posedge clk) disable iff (rst)
        done |-> !(c1 || c2 || c3 || rg || sg || clamp));

    // R9: gap strobe lasts a single cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R12: class changes only on pixel boundaries during a line
    a_r12_class_on_boundary: assert property (@(posedge clk) disable iff (rst)
        (!$stable(pclass) && busy_st) |-> (rg || done));

    // R1: idle for two cycles means quiet outputs
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (!busy_st && $past(!busy_st)) |-> !(c1 || c2 || c3 || rg || sg || clamp || done || (pclass != 2'd0)));
endmodule

bind ccd_hline_seq ccd_hline_seq_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .busy_st (busy),
    .c1      (reg_c1),
    .c2      (reg_c2),
    .c3      (reg_c3),
    .rg      (reset_gate),
    .sg      (sum_gate),
    .clamp   (clamp_win),
    .pclass  (pix_class),
    .done    (gap_start)
);

// File: tb/ccd_hline_seq_bench.sv
module ccd_hline_seq_bench;
    localparam int LINE_PIX = 1184;
    localparam int CLK_PIX  = 1079;
    localparam int LINE_CYC = LINE_PIX * 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0;
    logic       line_start = 1'b0;
    logic       reg_c1, reg_c2, reg_c3, reset_gate, sum_gate, clamp_win, gap_start;
    logic [1:0] pix_class;

    int checks = 0;
    int errors = 0;

    ccd_hline_seq u_ccd_hline_seq (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .line_start (line_start),
        .reg_c1     (reg_c1),
        .reg_c2     (reg_c2),
        .reg_c3     (reg_c3),
        .reset_gate (reset_gate),
        .sum_gate   (sum_gate),
        .clamp_win  (clamp_win),
        .pix_class  (pix_class),
        .gap_start  (gap_start)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic int exp_class(input int p);
        if (p < 7)    return 0;
        if (p < 27)   return 1;
        if (p < 31)   return 2;
        if (p < 1055) return 3;
        if (p < 1059) return 2;
        if (p < 1079) return 1;
        return 0;
    endfunction

    task automatic check_idle(input string tag);
        check({tag, " clocks"}, int'({reg_c1, reg_c2, reg_c3, reset_gate, sum_gate}), 0);
        check({tag, " flags"},  int'({clamp_win, gap_start, pix_class}), 0);
    endtask

    task automatic check_slot(input int t);
        int  p  = t / 6;
        int  s  = t % 6;
        bit  ck = p < CLK_PIX;
        bit  e1 = ck && (s <= 2);
        bit  e2 = ck && (s >= 2) && (s <= 4);
        bit  e3 = ck && ((s >= 4) || (s == 0));
        if (ck) check("R4 phases", int'({reg_c1, reg_c2, reg_c3}), int'({e1, e2, e3}));
        else    check("R8 gap clocks", int'({reg_c1, reg_c2, reg_c3, reset_gate, sum_gate, clamp_win}), 0);
        check("R5 reset gate", int'(reset_gate), int'(ck && (s == 0)));
        check("R6 summing gate", int'(sum_gate), int'(e3));
        check("R7 clamp window", int'(clamp_win), int'((p >= 1059) && (p < CLK_PIX)));
        check("R3 pixel class", int'(pix_class), exp_class(p));
        check("R9 gap strobe", int'(gap_start), int'((p == CLK_PIX) && (s == 0)));
    endtask

    // abort_t < 0 runs the full line; spray pulses line_start randomly (R10)
    task automatic run_line(input int abort_t, input bit spray);
        @(negedge clk) line_start = 1'b1;
        @(negedge clk) line_start = 1'b0;
        check_idle("R2 latency pre-start");
        for (int t = 0; t < LINE_CYC; t++) begin
            @(negedge clk);
            check_slot(t);
            line_start = (spray && (t <= LINE_CYC - 2)) ? 1'($urandom_range(0, 1)) : 1'b0;
            if (t == abort_t) begin
                line_start = 1'b0;
                enable = 1'b0;
                @(negedge clk) check_slot(t + 1);
                @(negedge clk) check_idle("R11 abort");
                return;
            end
        end
        line_start = 1'b0;
        @(negedge clk) check_idle("R10 line end");
        @(negedge clk) check_idle("R10 stays idle");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7351));
        repeat (3) @(posedge clk);
        @(negedge clk) begin rst = 1'b0; enable = 1'b1; end
        // R1: idle after reset
        repeat (4) @(negedge clk) check_idle("R1 reset idle");

        // R2, R3..R9: one plain line
        run_line(-1, 1'b0);
        // R10: line with triggers sprayed during it, then back-to-back
        run_line(-1, 1'b1);
        run_line(-1, 1'b0);

        // R11: abort at a random slot, then triggers while disabled
        run_line(int'($urandom_range(40, LINE_CYC - 10)), 1'b0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk) line_start = 1'b1;
            check_idle("R11 disabled trigger");
        end
        @(negedge clk) line_start = 1'b0;
        @(negedge clk) check_idle("R11 disabled trigger");
        enable = 1'b1;

        // R11 corner: abort on the first slot
        run_line(0, 1'b0);
        enable = 1'b1;

        // Random gaps between lines, random spray
        for (int k = 0; k < 2; k++) begin
            repeat ($urandom_range(1, 20)) @(negedge clk);
            run_line(-1, 1'($urandom_range(0, 1)));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule